// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block holds the software-visible control and status state of a multi-channel DMA engine. A CPU reaches it over a simple 32-bit register bus with a single-cycle write strobe and a combinational read port. It supplies the engine with a global configuration word, an interrupt enable mask and the channel start/stop words for each direction. For each channel it also holds a descriptor table pointer, and each receive channel has a buffer size. The transmit and receive channel counts are parameters, each between 1 and 32.

Five status words collect events from the datapath: one error word, plus an end-of-buffer word and a descriptor-error word for each direction. The datapath sets bits through per-bit set inputs. Software clears them by writing ones. Writing the configuration word with its top bit high acts as a soft reset. The status words, the interrupt mask and the channel start/stop words return to zero. The bit itself is never stored. Descriptor fetching, data movement and interrupt generation are outside this block.

Top module: `dmac_ctrl_regs`

## Requirements
- R1: After rst_ni is released, configuration reads 0x0007C000 and every other register reads 0.
- R2: Fixed word addresses are: configuration 0x180, error status 0x181, interrupt enable 0x182, TX start 0x184, TX stop 0x185, TX end-of-buffer 0x186, TX descriptor error 0x187, RX start 0x190, RX stop 0x191, RX end-of-buffer 0x192, RX descriptor error 0x193.
- R3: A configuration write stores the written value ANDed with 0x00FFC087, so bit 31 always reads back 0.
- R4: A configuration write with bit 31 set also clears, in the same clock, error status, interrupt enable, the four start/stop words and the four end-of-buffer/descriptor-error words.
- R5: Writing to any of the five status words clears each bit written as 1 and leaves bits written as 0 unchanged.
- R6: A bit whose set input is high in a cycle reads 1 afterwards, even if a clearing write or a soft reset hits that bit in the same cycle.
- R7: Interrupt enable keeps bits 4:0, the TX start/stop words keep bits 31:28 and the RX start/stop words keep bits 31:30; all other bits read 0.
- R8: The TX table pointer of channel i is at 0x1A0+i and the RX table pointer is at 0x1C0+i, both holding 32 bits. The RX buffer size is at 0x1E0+i and holds bits 7:0. Indices at or above the channel count are unmapped.
- R9: Reads from addresses that map to no register return 0.
- R10: Table pointers and buffer sizes keep their values across a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| err_set_i | input | 32 | Per-bit set for error status |
| tx_eob_set_i | input | 32 | Per-bit set for TX end-of-buffer status |
| tx_derr_set_i | input | 32 | Per-bit set for TX descriptor-error status |
| rx_eob_set_i | input | 32 | Per-bit set for RX end-of-buffer status |
| rx_derr_set_i | input | 32 | Per-bit set for RX descriptor-error status |
| cfg_o | output | 32 | Configuration word |
| irq_en_o | output | 32 | Interrupt enable mask |
| tx_start_o | output | 32 | TX channel start word |
| tx_stop_o | output | 32 | TX channel stop word |
| rx_start_o | output | 32 | RX channel start word |
| rx_stop_o | output | 32 | RX channel stop word |
| err_stat_o | output | 32 | Error status |
| tx_eob_o | output | 32 | TX end-of-buffer status |
| tx_derr_o | output | 32 | TX descriptor-error status |
| rx_eob_o | output | 32 | RX end-of-buffer status |
| rx_derr_o | output | 32 | RX descriptor-error status |
| tx_tptr_o | output | NUM_TX*32 | TX table pointers, channel i at bits 32i+31:32i |
| rx_tptr_o | output | NUM_RX*32 | RX table pointers |
| rx_bsize_o | output | NUM_RX*8 | RX buffer sizes |

## Verification
The hardest case to reach from the ports is a collision on one status bit: in the same clock edge, the datapath raises the bit and software either clears it or issues a soft reset. The bench gets there by driving the set inputs and the write strobe on the same falling edge, so both land on one rising edge. It then reads the words back. Sweeps over every table address are done once before and once after a soft reset. They show that the channel arrays stop at the configured counts and that the reset leaves them alone.

// File: rtl/dmac_reg_pkg.sv
package dmac_reg_pkg;
  localparam int A_CFG     = 'h180;
  localparam int A_ERR     = 'h181;
  localparam int A_IEN     = 'h182;
  localparam int A_TXSTART = 'h184;
  localparam int A_TXSTOP  = 'h185;
  localparam int A_TXEOB   = 'h186;
  localparam int A_TXDERR  = 'h187;
  localparam int A_RXSTART = 'h190;
  localparam int A_RXSTOP  = 'h191;
  localparam int A_RXEOB   = 'h192;
  localparam int A_RXDERR  = 'h193;
  localparam int A_TXTPTR  = 'h1A0;
  localparam int A_RXTPTR  = 'h1C0;
  localparam int A_RXBSIZE = 'h1E0;

  localparam logic [31:0] CFG_MASK  = 32'h00FFC087;
  localparam logic [31:0] CFG_RSTV  = 32'h0007C000;
  localparam logic [31:0] IEN_MASK  = 32'h0000001F;
  localparam logic [31:0] TXACT_MASK = 32'hF0000000;
  localparam logic [31:0] RXACT_MASK = 32'hC0000000;
  localparam int          SOFT_RST_BIT = 31;
endpackage

// File: rtl/dmac_mreg.sv
module dmac_mreg #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RSTV = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclr_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= RSTV;
    else if (we_i)    q <= wdata_i & MASK;
    else if (sclr_i)  q <= RSTV;
  end

  assign q_o = q;
endmodule

// File: rtl/dmac_w1c.sv
module dmac_w1c #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclr_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q, kept;

  always_comb begin
    if (sclr_i)    kept = '0;
    else if (we_i) kept = q & ~wdata_i;
    else           kept = q;
  end

  // hardware set dominates clear and soft reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= kept | set_i;
  end

  assign q_o = q;
endmodule

// File: rtl/dmac_chan_array.sv
module dmac_chan_array #(
  parameter int ADDR_W = 10,
  parameter int BASE   = 'h1A0,
  parameter int N      = 4,
  parameter int W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic              hit_o,
  output logic [31:0]       rdata_o,
  output logic [N*W-1:0]    regs_o
);
  logic [N-1:0]  hit;
  logic [W-1:0]  q [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign hit[i] = (addr_i == ADDR_W'(BASE + i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q[i] <= '0;
      else if (we_i && hit[i])    q[i] <= wdata_i[W-1:0];
    end
    assign regs_o[i*W +: W] = q[i];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (hit[i]) rdata_o = rdata_o | 32'(q[i]);
  end

  assign hit_o = |hit;
endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
  import dmac_reg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NUM_TX = 4,
  parameter int NUM_RX = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_we_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  input  logic [31:0]         err_set_i,
  input  logic [31:0]         tx_eob_set_i,
  input  logic [31:0]         tx_derr_set_i,
  input  logic [31:0]         rx_eob_set_i,
  input  logic [31:0]         rx_derr_set_i,
  output logic [31:0]         cfg_o,
  output logic [31:0]         irq_en_o,
  output logic [31:0]         tx_start_o,
  output logic [31:0]         tx_stop_o,
  output logic [31:0]         rx_start_o,
  output logic [31:0]         rx_stop_o,
  output logic [31:0]         err_stat_o,
  output logic [31:0]         tx_eob_o,
  output logic [31:0]         tx_derr_o,
  output logic [31:0]         rx_eob_o,
  output logic [31:0]         rx_derr_o,
  output logic [NUM_TX*32-1:0] tx_tptr_o,
  output logic [NUM_RX*32-1:0] rx_tptr_o,
  output logic [NUM_RX*8-1:0]  rx_bsize_o
);
  localparam int NSTAT = 5;

  function automatic logic sel(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  logic soft_rst;
  assign soft_rst = reg_we_i && sel(reg_addr_i, A_CFG) && reg_wdata_i[SOFT_RST_BIT];

  // configuration: bit 31 is masked off, so the soft reset self-clears
  dmac_mreg #(.W(32), .MASK(CFG_MASK), .RSTV(CFG_RSTV)) u_cfg (
    .clk_i, .rst_ni, .sclr_i(1'b0),
    .we_i(reg_we_i && sel(reg_addr_i, A_CFG)),
    .wdata_i(reg_wdata_i), .q_o(cfg_o));

  dmac_mreg #(.W(32), .MASK(IEN_MASK)) u_ien (
    .clk_i, .rst_ni, .sclr_i(soft_rst),
    .we_i(reg_we_i && sel(reg_addr_i, A_IEN)),
    .wdata_i(reg_wdata_i), .q_o(irq_en_o));

  dmac_mreg #(.W(32), .MASK(TXACT_MASK)) u_tx_start (
    .clk_i, .rst_ni, .sclr_i(soft_rst),
    .we_i(reg_we_i && sel(reg_addr_i, A_TXSTART)),
    .wdata_i(reg_wdata_i), .q_o(tx_start_o));

  dmac_mreg #(.W(32), .MASK(TXACT_MASK)) u_tx_stop (
    .clk_i, .rst_ni, .sclr_i(soft_rst),
    .we_i(reg_we_i && sel(reg_addr_i, A_TXSTOP)),
    .wdata_i(reg_wdata_i), .q_o(tx_stop_o));

  dmac_mreg #(.W(32), .MASK(RXACT_MASK)) u_rx_start (
    .clk_i, .rst_ni, .sclr_i(soft_rst),
    .we_i(reg_we_i && sel(reg_addr_i, A_RXSTART)),
    .wdata_i(reg_wdata_i), .q_o(rx_start_o));

  dmac_mreg #(.W(32), .MASK(RXACT_MASK)) u_rx_stop (
    .clk_i, .rst_ni, .sclr_i(soft_rst),
    .we_i(reg_we_i && sel(reg_addr_i, A_RXSTOP)),
    .wdata_i(reg_wdata_i), .q_o(rx_stop_o));

  // status words
  localparam int STAT_ADDR [NSTAT] = '{A_ERR, A_TXEOB, A_TXDERR, A_RXEOB, A_RXDERR};
  logic [31:0] stat_set [NSTAT];
  logic [31:0] stat_q   [NSTAT];

  assign stat_set[0] = err_set_i;
  assign stat_set[1] = tx_eob_set_i;
  assign stat_set[2] = tx_derr_set_i;
  assign stat_set[3] = rx_eob_set_i;
  assign stat_set[4] = rx_derr_set_i;

  for (genvar s = 0; s < NSTAT; s++) begin : g_stat
    dmac_w1c #(.W(32)) u_w1c (
      .clk_i, .rst_ni, .sclr_i(soft_rst),
      .we_i(reg_we_i && sel(reg_addr_i, STAT_ADDR[s])),
      .wdata_i(reg_wdata_i), .set_i(stat_set[s]), .q_o(stat_q[s]));
  end

  assign err_stat_o = stat_q[0];
  assign tx_eob_o   = stat_q[1];
  assign tx_derr_o  = stat_q[2];
  assign rx_eob_o   = stat_q[3];
  assign rx_derr_o  = stat_q[4];

  // per-channel arrays
  logic        txp_hit, rxp_hit, rxs_hit;
  logic [31:0] txp_rd, rxp_rd, rxs_rd;

  dmac_chan_array #(.ADDR_W(ADDR_W), .BASE(A_TXTPTR), .N(NUM_TX), .W(32)) u_tx_tptr (
    .clk_i, .rst_ni, .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .hit_o(txp_hit), .rdata_o(txp_rd), .regs_o(tx_tptr_o));

  dmac_chan_array #(.ADDR_W(ADDR_W), .BASE(A_RXTPTR), .N(NUM_RX), .W(32)) u_rx_tptr (
    .clk_i, .rst_ni, .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .hit_o(rxp_hit), .rdata_o(rxp_rd), .regs_o(rx_tptr_o));

  dmac_chan_array #(.ADDR_W(ADDR_W), .BASE(A_RXBSIZE), .N(NUM_RX), .W(8)) u_rx_bsize (
    .clk_i, .rst_ni, .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .hit_o(rxs_hit), .rdata_o(rxs_rd), .regs_o(rx_bsize_o));

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    if      (sel(reg_addr_i, A_CFG))     reg_rdata_o = cfg_o;
    else if (sel(reg_addr_i, A_IEN))     reg_rdata_o = irq_en_o;
    else if (sel(reg_addr_i, A_TXSTART)) reg_rdata_o = tx_start_o;
    else if (sel(reg_addr_i, A_TXSTOP))  reg_rdata_o = tx_stop_o;
    else if (sel(reg_addr_i, A_RXSTART)) reg_rdata_o = rx_start_o;
    else if (sel(reg_addr_i, A_RXSTOP))  reg_rdata_o = rx_stop_o;
    else if (txp_hit)                    reg_rdata_o = txp_rd;
    else if (rxp_hit)                    reg_rdata_o = rxp_rd;
    else if (rxs_hit)                    reg_rdata_o = rxs_rd;
    else begin
      for (int s = 0; s < NSTAT; s++)
        if (sel(reg_addr_i, STAT_ADDR[s])) reg_rdata_o = stat_q[s];
    end
  end
endmodule

// File: rtl/dmac_ctrl_regs_chk.sv
module dmac_ctrl_regs_chk #(
  parameter int ADDR_W = 10,
  parameter int NUM_TX = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic                 reg_we_i,
  input logic [31:0]          reg_wdata_i,
  input logic [31:0]          reg_rdata_o,
  input logic [31:0]          err_set_i,
  input logic [31:0]          err_stat_o,
  input logic [31:0]          cfg_o,
  input logic [31:0]          irq_en_o,
  input logic [NUM_TX*32-1:0] tx_tptr_o
);
  logic cfg_wr, err_wr, ien_wr;
  assign cfg_wr = reg_we_i && (reg_addr_i == ADDR_W'('h180));
  assign err_wr = reg_we_i && (reg_addr_i == ADDR_W'('h181));
  assign ien_wr = reg_we_i && (reg_addr_i == ADDR_W'('h182));

  p_cfg_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr |=> cfg_o == ($past(reg_wdata_i) & 32'h00FFC087));

  p_soft_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr && reg_wdata_i[31] |=> irq_en_o == 32'h0);

  p_w1c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_wr |=> (err_stat_o & $past(reg_wdata_i) & ~$past(err_set_i)) == 32'h0);

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_i != 32'h0 |=> (err_stat_o & $past(err_set_i)) == $past(err_set_i));

  p_ien_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_wr |=> irq_en_o == ($past(reg_wdata_i) & 32'h1F));

  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i == ADDR_W'('h183) |-> reg_rdata_o == 32'h0);

  p_tptr_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr |=> $stable(tx_tptr_o));
endmodule

bind dmac_ctrl_regs dmac_ctrl_regs_chk #(.ADDR_W(ADDR_W), .NUM_TX(NUM_TX)) u_chk (
  .clk_i, .rst_ni, .reg_addr_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o,
  .err_set_i, .err_stat_o, .cfg_o, .irq_en_o, .tx_tptr_o);

// File: tb/dmac_ctrl_regs_tb.sv
`timescale 1ns/1ps
module dmac_ctrl_regs_tb;
  localparam int ADDR_W = 10;
  localparam int NTX = 4;
  localparam int NRX = 2;

  logic clk = 0, rst_n = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic we = 0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] s_err = '0, s_teob = '0, s_tder = '0, s_reob = '0, s_rder = '0;
  logic [31:0] cfg, ien, txs, txp, rxs, rxp, est, teob, tder, reob, rder;
  logic [NTX*32-1:0] ttp;
  logic [NRX*32-1:0] rtp;
  logic [NRX*8-1:0]  rbs;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  dmac_ctrl_regs #(.ADDR_W(ADDR_W), .NUM_TX(NTX), .NUM_RX(NRX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .err_set_i(s_err), .tx_eob_set_i(s_teob), .tx_derr_set_i(s_tder),
    .rx_eob_set_i(s_reob), .rx_derr_set_i(s_rder),
    .cfg_o(cfg), .irq_en_o(ien), .tx_start_o(txs), .tx_stop_o(txp),
    .rx_start_o(rxs), .rx_stop_o(rxp), .err_stat_o(est), .tx_eob_o(teob),
    .tx_derr_o(tder), .rx_eob_o(reob), .rx_derr_o(rder),
    .tx_tptr_o(ttp), .rx_tptr_o(rtp), .rx_bsize_o(rbs));

  localparam int STATS [5] = '{'h181, 'h186, 'h187, 'h192, 'h193};

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; we = 1;
    @(negedge clk);
    we = 0; s_err = '0; s_teob = '0; s_tder = '0; s_reob = '0; s_rder = '0;
  endtask

  task automatic set_all(input logic [31:0] v);
    @(negedge clk);
    s_err = v; s_teob = v; s_tder = v; s_reob = v; s_rder = v;
    @(negedge clk);
    s_err = '0; s_teob = '0; s_tder = '0; s_reob = '0; s_rder = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string req);
    addr = ADDR_W'(a);
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr=0x%03h actual=0x%08h expected=0x%08h", req, a, rdata, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    return 32'hA55A0000 ^ (32'(a) * 32'h01030507);
  endfunction

  function automatic logic [31:0] tbl_exp(input int a);
    int idx = a & 'h1F;
    if (a >= 'h1A0 && a < 'h1C0) return (idx < NTX) ? pat(a) : 32'h0;
    if (a >= 'h1C0 && a < 'h1E0) return (idx < NRX) ? pat(a) : 32'h0;
    return (idx < NRX) ? (pat(a) & 32'hFF) : 32'h0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1, R9: reset values over the whole address space
    for (int a = 0; a < (1 << ADDR_W); a++)
      rd(a, (a == 'h180) ? 32'h0007C000 : 32'h0, "R1/R9");

    // R3: config masking, bit 31 clear
    wr('h180, 32'h7FFFFFFF);
    rd('h180, 32'h00FFC087, "R3");
    wr('h180, 32'h12345678);
    rd('h180, 32'h12345678 & 32'h00FFC087, "R3");

    // R2, R7: masks on enable and start/stop words
    wr('h182, 32'hFFFFFFFF); rd('h182, 32'h0000001F, "R7");
    wr('h184, 32'hFFFFFFFF); rd('h184, 32'hF0000000, "R7");
    wr('h185, 32'h5FFFFFFF); rd('h185, 32'h50000000, "R7");
    wr('h190, 32'hFFFFFFFF); rd('h190, 32'hC0000000, "R7");
    wr('h191, 32'h7FFFFFFF); rd('h191, 32'h40000000, "R7");
    rd('h183, 32'h0, "R9");
    rd('h188, 32'h0, "R9");

    // R6: hardware set fills status words; R5: clear-by-one
    set_all(32'hFFFFFFFF);
    foreach (STATS[k]) rd(STATS[k], 32'hFFFFFFFF, "R6");
    foreach (STATS[k]) wr(STATS[k], 32'h0000FFFF);
    foreach (STATS[k]) rd(STATS[k], 32'hFFFF0000, "R5");
    foreach (STATS[k]) wr(STATS[k], 32'h00000000);
    foreach (STATS[k]) rd(STATS[k], 32'hFFFF0000, "R5");

    // R6: set and clear on the same bit in the same cycle
    @(negedge clk);
    addr = 10'h181; wdata = 32'hFFFFFFFF; we = 1; s_err = 32'h00010001;
    @(negedge clk);
    we = 0; s_err = '0;
    rd('h181, 32'h00010001, "R6");

    // R8: table sweep including out-of-range indices
    for (int a = 'h1A0; a < 'h200; a++) wr(a, pat(a));
    for (int a = 'h1A0; a < 'h200; a++) rd(a, tbl_exp(a), "R8");

    // R4 with R6 collision on TX end-of-buffer bit 3
    set_all(32'h0F0F0F0F);
    @(negedge clk);
    addr = 10'h180; wdata = 32'h80000001; we = 1; s_teob = 32'h00000008;
    @(negedge clk);
    we = 0; s_teob = '0;
    rd('h180, 32'h00000001, "R4");
    rd('h181, 32'h0, "R4");
    rd('h182, 32'h0, "R4");
    rd('h184, 32'h0, "R4");
    rd('h185, 32'h0, "R4");
    rd('h190, 32'h0, "R4");
    rd('h191, 32'h0, "R4");
    rd('h186, 32'h00000008, "R6");
    rd('h187, 32'h0, "R4");
    rd('h192, 32'h0, "R4");
    rd('h193, 32'h0, "R4");

    // R10: tables survive soft reset
    for (int a = 'h1A0; a < 'h200; a++) rd(a, tbl_exp(a), "R10");

    summary();
    $finish;
  end
endmodule